// File: doc/BRIEF.md
# Amplifier Control and Status Serial Link

This block connects a host register bus to one or more multi-channel power amplifier boards over a four-wire synchronous serial link. The four wires are a serial clock, a control data output, a status data input and a latch strobe. Each link holds two control bytes written by the host. A transfer shifts those two bytes out to the amplifier. The same transfer shifts two status bytes in, and they land in two read-only status bytes the host can read. Among the control bits are one relay-enable acknowledge per amplifier channel, which connects that channel's speaker terminals to its output.

In the status data, the first byte returned is an echo of the first control byte the amplifier received in the transfer before. The second byte carries four clip flags in its upper nibble and four ready flags in its lower nibble. Because of the echo, the host can compare what it sent with what came back and so check the loop. The block itself does not decode the status bits; it stores them.

A transfer starts when the host requests one. In auto-repeat mode the link also restarts after a fixed idle gap, so the status is refreshed continuously. Each link has its own clock divider, its own state and its own registers. The default build has two links, which run independently.

Top module: `amp_link_ctrl`

## Requirements
- R1: After reset, all serial outputs are low on every link. The control, status and command registers read 0x00, and the divider register reads 0x03.
- R2: The host address is {link, sel}, with the link index in bit 3 and sel in bits 2:0. The sel values are: 0 = first control byte (read/write), 1 = second control byte (read/write), 2 = first status byte (read-only), 3 = second status byte (read-only), 4 = command, 5 = divider (read/write). Sel values 6 and 7 read 0x00. Writes to sel 2 and sel 3 are ignored.
- R3: The serial clock idles low. During a transfer each half period lasts DIV+1 system clock cycles, where DIV is the divider register value, and the clock gives exactly 16 high pulses.
- R4: The control output sends the first control byte and then the second, each most significant bit first. Each bit is valid while the serial clock is low, before its rising edge, and changes only when the serial clock falls. The output is low outside the shift phase.
- R5: The status input is sampled on the system clock edge that raises the serial clock. The first sampled bit becomes bit 7 of the first status byte, and the sixteenth becomes bit 0 of the second status byte.
- R6: After the 16th falling edge of the serial clock, the latch strobe is high for two half periods while the serial clock stays low. Both status bytes are updated on the edge where the latch strobe falls, and at no other time.
- R7: Writing the command register with bit 0 set raises the pending flag. If the link is idle, the transfer loads on the next clock edge and the pending flag clears. If a transfer is in progress, the pending flag holds and the next transfer starts right after the current one ends.
- R8: A transfer shifts the control bytes as they stood just before its load edge. Host writes on the load edge or later apply only to the next transfer.
- R9: Command bit 1 sets auto-repeat. While auto-repeat is set, a new transfer starts after an idle gap of 4 half periods that follows the falling edge of the latch strobe. If auto-repeat is cleared during the gap, the link goes idle at once.
- R10: Reading the command register returns pending in bit 0, auto-repeat in bit 1 and busy in bit 2. Busy is high from the load edge until the latch strobe falls.
- R11: Each link has its own divider, registers and sequencing. Activity on one link does not change the outputs or registers of another link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host address {link, sel} |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| amp_sclk | output | 2 | Serial clock, one bit per link |
| amp_ctrl_out | output | 2 | Control data toward the amplifier, one bit per link |
| amp_stat_in | input | 2 | Status data from the amplifier, one bit per link |
| amp_latch | output | 2 | Latch strobe, one bit per link |

## Verification
Two events can fall on the same clock edge: a host write to a control byte, and the load of that byte into the shift register. The bench provokes this by writing the start command and then, in the very next cycle, writing a new value to the first control byte. The load edge and the write edge then coincide. The result is judged two ways. The serial waveform is compared on every cycle against a behavioural timeline model. The status echo returned two transfers later must show the old byte, not the new one.

// File: rtl/amp_link_pkg.sv
package amp_link_pkg;

    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;
    localparam int SEL_W   = 3;

    localparam int CMD_START = 0;
    localparam int CMD_AUTO  = 1;
    localparam int CMD_BUSY  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2,
        ST_GAP   = 2'd3
    } link_state_e;

    typedef enum logic [SEL_W-1:0] {
        REG_CTRL0 = 3'd0,
        REG_CTRL1 = 3'd1,
        REG_STAT0 = 3'd2,
        REG_STAT1 = 3'd3,
        REG_CMD   = 3'd4,
        REG_DIV   = 3'd5
    } reg_sel_e;

    // hi is shifted first
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } frame_t;

    function automatic logic [BYTE_W-1:0] pack_cmd(input logic pend,
                                                   input logic auto_on,
                                                   input logic busy);
        logic [BYTE_W-1:0] v;
        v            = '0;
        v[CMD_START] = pend;
        v[CMD_AUTO]  = auto_on;
        v[CMD_BUSY]  = busy;
        return v;
    endfunction

endpackage

// File: rtl/amp_link_tick.sv
module amp_link_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || clr) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div != '0) |=> (!tick_o || div == '0));

endmodule

// File: rtl/amp_link_engine.sv
module amp_link_engine
    import amp_link_pkg::*;
#(
    parameter int GAP_HALVES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   start_pend,
    input  logic   auto_en,
    input  frame_t tx_frame,
    input  logic   din,
    output logic   run_o,
    output logic   load_o,
    output logic   ack_o,
    output logic   commit_o,
    output logic   busy_o,
    output frame_t rx_o,
    output logic   sclk_o,
    output logic   dout_o,
    output logic   latch_o
);

    localparam int BIT_W = $clog2(FRAME_W);
    localparam int GAP_W = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_HALVES - 1);

    link_state_e        state_q;
    logic               phase_q;
    logic               half_q;
    logic [BIT_W-1:0]   bit_q;
    logic [GAP_W-1:0]   gap_q;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] rx_q;
    logic               gap_done;

    always_comb begin
        gap_done = (state_q == ST_GAP) && tick && (gap_q == LAST_GAP);
        load_o   = (start_pend && (state_q == ST_IDLE || state_q == ST_GAP))
                 || (gap_done && auto_en);
        ack_o    = load_o && start_pend;
        commit_o = (state_q == ST_LATCH) && tick && half_q;
        busy_o   = (state_q == ST_SHIFT) || (state_q == ST_LATCH);
        run_o    = (state_q != ST_IDLE);
        dout_o   = (state_q == ST_SHIFT) && sh_q[FRAME_W-1];
        rx_o     = rx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            half_q  <= 1'b0;
            bit_q   <= '0;
            gap_q   <= '0;
            sh_q    <= '0;
            rx_q    <= '0;
            sclk_o  <= 1'b0;
            latch_o <= 1'b0;
        end else if (load_o) begin
            state_q <= ST_SHIFT;
            sh_q    <= tx_frame;
            bit_q   <= '0;
            phase_q <= 1'b0;
            sclk_o  <= 1'b0;
            latch_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SHIFT: if (tick) begin
                    if (!phase_q) begin
                        sclk_o  <= 1'b1;
                        phase_q <= 1'b1;
                        rx_q    <= {rx_q[FRAME_W-2:0], din};
                    end else begin
                        sclk_o  <= 1'b0;
                        phase_q <= 1'b0;
                        if (bit_q == LAST_BIT) begin
                            state_q <= ST_LATCH;
                            latch_o <= 1'b1;
                            half_q  <= 1'b0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
                ST_LATCH: if (tick) begin
                    if (!half_q) begin
                        half_q <= 1'b1;
                    end else begin
                        latch_o <= 1'b0;
                        gap_q   <= '0;
                        state_q <= auto_en ? ST_GAP : ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (!auto_en) begin
                        state_q <= ST_IDLE;
                    end else if (tick) begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    latch_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(latch_o && sclk_o));

    // R3
    sclk_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sclk_o));

    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(dout_o));

    // R6
    commit_fall_chk: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> $fell(latch_o));

endmodule

// File: rtl/amp_link_regs.sv
module amp_link_regs
    import amp_link_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              busy,
    input  logic              ack,
    input  logic              commit,
    input  frame_t            rx_frame,
    output frame_t            ctrl_o,
    output logic              pend_o,
    output logic              auto_o,
    output logic [DIV_W-1:0]  div_o
);

    frame_t ctrl_q;
    frame_t stat_q;
    logic   pend_q;
    logic   auto_q;
    logic [DIV_W-1:0] div_q;
    logic   start_wr;

    assign start_wr = we && (reg_sel_e'(sel) == REG_CMD) && wdata[CMD_START];
    assign ctrl_o   = ctrl_q;
    assign pend_o   = pend_q;
    assign auto_o   = auto_q;
    assign div_o    = div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            pend_q <= 1'b0;
            auto_q <= 1'b0;
            div_q  <= DIV_W'(DIV_RESET);
        end else begin
            if (start_wr) begin
                pend_q <= 1'b1;
            end else if (ack) begin
                pend_q <= 1'b0;
            end
            if (commit) begin
                stat_q <= rx_frame;
            end
            if (we) begin
                case (reg_sel_e'(sel))
                    REG_CTRL0: ctrl_q.hi <= wdata;
                    REG_CTRL1: ctrl_q.lo <= wdata;
                    REG_CMD:   auto_q    <= wdata[CMD_AUTO];
                    REG_DIV:   div_q     <= wdata[DIV_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_sel_e'(sel))
            REG_CTRL0: rdata = ctrl_q.hi;
            REG_CTRL1: rdata = ctrl_q.lo;
            REG_STAT0: rdata = stat_q.hi;
            REG_STAT1: rdata = stat_q.lo;
            REG_CMD:   rdata = pack_cmd(pend_q, auto_q, busy);
            REG_DIV:   rdata = BYTE_W'(div_q);
            default:   rdata = '0;
        endcase
    end

    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(stat_q));

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> pend_q);

endmodule

// File: rtl/amp_link_ctrl.sv
module amp_link_ctrl
    import amp_link_pkg::*;
#(
    parameter int NUM_LINKS  = 2,
    parameter int DIV_W      = 8,
    parameter int DIV_RESET  = 3,
    parameter int GAP_HALVES = 4,
    localparam int LINK_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int ADDR_W    = LINK_W + SEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [BYTE_W-1:0]    host_wdata,
    output logic [BYTE_W-1:0]    host_rdata,
    output logic [NUM_LINKS-1:0] amp_sclk,
    output logic [NUM_LINKS-1:0] amp_ctrl_out,
    input  logic [NUM_LINKS-1:0] amp_stat_in,
    output logic [NUM_LINKS-1:0] amp_latch
);

    logic [LINK_W-1:0] link_sel;
    logic [SEL_W-1:0]  reg_sel;
    logic [BYTE_W-1:0] rd_arr [NUM_LINKS];

    assign link_sel = host_addr[ADDR_W-1:SEL_W];
    assign reg_sel  = host_addr[SEL_W-1:0];

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        logic             we_l;
        logic             tick;
        logic             run, load, ack, commit, busy, pend, auto_on;
        frame_t           ctrl, rx;
        logic [DIV_W-1:0] div;

        assign we_l = host_we && (link_sel == LINK_W'(i));

        amp_link_regs #(
            .DIV_W     (DIV_W),
            .DIV_RESET (DIV_RESET)
        ) u_regs (
            .clk      (clk),
            .rst      (rst),
            .we       (we_l),
            .sel      (reg_sel),
            .wdata    (host_wdata),
            .rdata    (rd_arr[i]),
            .busy     (busy),
            .ack      (ack),
            .commit   (commit),
            .rx_frame (rx),
            .ctrl_o   (ctrl),
            .pend_o   (pend),
            .auto_o   (auto_on),
            .div_o    (div)
        );

        amp_link_tick #(
            .DIV_W (DIV_W)
        ) u_tick (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .clr    (load),
            .div    (div),
            .tick_o (tick)
        );

        amp_link_engine #(
            .GAP_HALVES (GAP_HALVES)
        ) u_eng (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .start_pend (pend),
            .auto_en    (auto_on),
            .tx_frame   (ctrl),
            .din        (amp_stat_in[i]),
            .run_o      (run),
            .load_o     (load),
            .ack_o      (ack),
            .commit_o   (commit),
            .busy_o     (busy),
            .rx_o       (rx),
            .sclk_o     (amp_sclk[i]),
            .dout_o     (amp_ctrl_out[i]),
            .latch_o    (amp_latch[i])
        );
    end

    always_comb begin
        host_rdata = '0;
        for (int k = 0; k < NUM_LINKS; k++) begin
            if (link_sel == LINK_W'(k)) begin
                host_rdata = rd_arr[k];
            end
        end
    end

endmodule

// File: tb/tb_amp_link_ctrl.sv
module tb_amp_link_ctrl;

    localparam int NL  = 2;
    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [1:0] sclk, cout, latch;
    logic [1:0] sin = '0;

    always #10 clk = ~clk;

    amp_link_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .amp_sclk     (sclk),
        .amp_ctrl_out (cout),
        .amp_stat_in  (sin),
        .amp_latch    (latch)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int cyc = 0;

    // behavioural timeline model: state 0 idle, 1 transfer, 2 gap
    int          m_st [NL], m_cnt [NL], m_h [NL], m_g [NL], m_div [NL];
    bit          m_pend [NL], m_auto [NL];
    logic [7:0]  m_c0 [NL], m_c1 [NL];
    logic [15:0] m_sh [NL];

    // amplifier model
    bit          a_ps [NL], a_pl [NL];
    logic [15:0] a_tx [NL], a_rx [NL];
    logic [7:0]  a_clip [NL];
    int          a_ptr [NL];

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL R7 watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
        if (rst) begin
            for (int i = 0; i < NL; i++) begin
                m_st[i] = 0; m_cnt[i] = 0; m_h[i] = 0; m_g[i] = 0; m_div[i] = 3;
                m_pend[i] = 0; m_auto[i] = 0; m_c0[i] = '0; m_c1[i] = '0; m_sh[i] = '0;
            end
        end else begin
            for (int i = 0; i < NL; i++) begin
                bit regw, stw, tk, ld, ack;
                int oldst;
                regw  = host_we && (int'(host_addr[3]) == i);
                stw   = regw && (host_addr[2:0] == 3'd4) && host_wdata[0];
                oldst = m_st[i];
                tk    = (oldst != 0) && (m_cnt[i] == m_div[i]);
                ld    = 0;
                case (oldst)
                    0: ld = m_pend[i];
                    1: if (tk) begin
                        m_h[i]++;
                        if (m_h[i] == 34) begin
                            m_st[i] = m_auto[i] ? 2 : 0;
                            m_g[i]  = 0;
                        end
                    end
                    default: begin
                        if (m_pend[i]) ld = 1;
                        else if (!m_auto[i]) m_st[i] = 0;
                        else if (tk) begin
                            m_g[i]++;
                            if (m_g[i] == GAP) ld = 1;
                        end
                    end
                endcase
                if (oldst == 0 || ld || tk) m_cnt[i] = 0;
                else m_cnt[i]++;
                ack = ld && m_pend[i];
                if (ld) begin
                    m_st[i] = 1; m_h[i] = 0; m_sh[i] = {m_c0[i], m_c1[i]};
                end
                m_pend[i] = (m_pend[i] && !ack) || stw;
                if (regw) begin
                    case (host_addr[2:0])
                        3'd0: m_c0[i] = host_wdata;
                        3'd1: m_c1[i] = host_wdata;
                        3'd4: m_auto[i] = host_wdata[1];
                        3'd5: m_div[i] = int'(host_wdata);
                        default: ;
                    endcase
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < NL; i++) begin
                int es, ed, el;
                if (sclk[i] && !a_ps[i]) a_rx[i] = {a_rx[i][14:0], cout[i]};
                if (!sclk[i] && a_ps[i]) a_ptr[i]++;
                if (!latch[i] && a_pl[i]) begin
                    a_tx[i]  = {a_rx[i][15:8], a_clip[i]};
                    a_ptr[i] = 0;
                end
                a_ps[i] = sclk[i];
                a_pl[i] = latch[i];
                sin[i]  = (a_ptr[i] < 16) ? a_tx[i][15 - a_ptr[i]] : 1'b0;

                es = (m_st[i] == 1 && m_h[i] < 32 && (m_h[i] % 2) == 1) ? 1 : 0;
                ed = (m_st[i] == 1 && m_h[i] < 32) ? int'(m_sh[i][15 - m_h[i] / 2]) : 0;
                el = (m_st[i] == 1 && m_h[i] >= 32) ? 1 : 0;
                chk($sformatf("R3 R11 link%0d sclk cyc%0d", i, cyc), int'(sclk[i]), es);
                chk($sformatf("R4 R8 link%0d ctrl_out cyc%0d", i, cyc), int'(cout[i]), ed);
                chk($sformatf("R6 R9 link%0d latch cyc%0d", i, cyc), int'(latch[i]), el);
            end
        end
    end

    task automatic wr(int a, int d);
        host_we    = 1'b1;
        host_addr  = 4'(a);
        host_wdata = 8'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        host_addr = 4'(a);
        #1;
        v = int'(host_rdata);
        @(negedge clk);
    endtask

    task automatic chk_rd(string tag, int a, int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic chk_cmd(string tag, int l);
        int v, e;
        rd(l * 8 + 4, v);
        e = ((m_st[l] == 1) ? 4 : 0) | (m_auto[l] ? 2 : 0) | (m_pend[l] ? 1 : 0);
        chk(tag, v, e);
    endtask

    task automatic wait_idle(int l);
        int v;
        do rd(l * 8 + 4, v); while ((v & 5) != 0);
    endtask

    initial begin
        a_clip[0] = 8'h9F;
        a_clip[1] = 8'h6A;
        for (int i = 0; i < NL; i++) begin
            a_tx[i] = {8'h00, a_clip[i]};
            a_rx[i] = '0; a_ptr[i] = 0; a_ps[i] = 0; a_pl[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        for (int l = 0; l < NL; l++) begin
            chk_rd("R1 ctrl0", l * 8 + 0, 0);
            chk_rd("R1 ctrl1", l * 8 + 1, 0);
            chk_rd("R1 stat0", l * 8 + 2, 0);
            chk_rd("R1 stat1", l * 8 + 3, 0);
            chk_rd("R1 cmd",   l * 8 + 4, 0);
            chk_rd("R1 div",   l * 8 + 5, 3);
            chk_rd("R2 unused sel", l * 8 + 6, 0);
        end

        // R2 register map
        wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hFF); wr(3, 8'hFF);
        wr(13, 0); wr(8, 8'hC3); wr(9, 8'h81);
        chk_rd("R2 ctrl0 A", 0, 8'hA5);
        chk_rd("R2 ctrl1 A", 1, 8'h3C);
        chk_rd("R2 stat0 write ignored", 2, 0);
        chk_rd("R2 stat1 write ignored", 3, 0);
        chk_rd("R2 div B", 13, 0);
        chk_rd("R11 ctrl0 B", 8, 8'hC3);
        chk_rd("R11 div A untouched", 5, 3);

        // R7 R10 start timing
        wr(4, 1);
        chk_rd("R7 pending before load", 4, 8'h01);
        chk_rd("R10 busy after load", 4, 8'h04);
        wait_idle(0);
        chk_rd("R5 stat0 first echo", 2, 8'h00);
        chk_rd("R5 stat1 clip/ready", 3, 8'h9F);
        chk_rd("R11 link B stat untouched", 11, 0);

        // R8 write on the load edge
        wr(4, 1); wr(0, 8'h5A);
        wait_idle(0);
        chk_rd("R5 stat0 echo T1", 2, 8'hA5);
        wr(4, 1); wait_idle(0);
        chk_rd("R8 stat0 echo T2 used old byte", 2, 8'hA5);
        wr(4, 1); wait_idle(0);
        chk_rd("R8 stat0 echo T3 new byte", 2, 8'h5A);

        // R7 start during busy
        wr(4, 1);
        repeat (10) @(negedge clk);
        wr(4, 1);
        chk_rd("R7 pending while busy", 4, 8'h05);
        chk_cmd("R10 cmd vs model", 0);
        wait_idle(0);
        chk_cmd("R7 idle after queued transfer", 0);

        // R3 faster divider on A
        wr(5, 1); wr(4, 1); wait_idle(0);

        // R9 R11 auto on B with start on A concurrently
        wr(12, 3); wr(4, 3);
        repeat (400) @(negedge clk);
        chk_cmd("R9 auto flag A", 0);
        chk_cmd("R9 auto flag B", 1);
        wr(12, 0);
        repeat (37) @(negedge clk);
        wr(4, 0);
        wait_idle(1);
        wait_idle(0);
        repeat (20) @(negedge clk);
        chk_cmd("R9 B idle after auto cleared", 1);
        chk_rd("R11 stat0 B echo", 10, 8'hC3);
        chk_rd("R11 stat1 B clip/ready", 11, 8'h6A);
        chk_rd("R5 stat1 A", 3, 8'h9F);
        chk_rd("R9 stat0 A echo", 2, 8'h5A);

        finish_run();
    end

endmodule